// File: doc/BRIEF.md
# Startup Output Short Check Sequencer

This block decides when a multi-half-bridge power output stage may begin switching after its logic supply comes up. Once per supply power-up it runs a two-phase test on every half-bridge output. First it looks for outputs shorted to ground, then for outputs shorted to the power rail. While the test runs, every half-bridge is held in high impedance and the active-low shutdown line is held asserted. The analog test currents are not part of the block. Each half-bridge supplies one comparator bit per phase, and the sequencer qualifies those bits in time.

Each phase first waits a programmable settle count. It then needs a run of consecutive clean samples before it passes. A short seen during sampling restarts that run. A phase that has not passed within its timeout window restarts its settle and sampling from scratch, while the outputs stay held. When both phases pass, the block issues a one-cycle start-switching strobe and then raises ready. The device reset pin has no effect while the test runs, and a later device reset does not run the test again. In single-ended output mode the test is skipped. An overcurrent event drops ready and latches the stage off until a device reset.

States:
- OFF: supply not valid.
- GND_TEST: ground-short phase.
- SUP_TEST: rail-short phase.
- LAUNCH: one cycle that issues the strobe.
- RUN: switching.
- HALT: device reset held.
- TRIP: overcurrent latched.

Transitions:
- supply loss: any state to OFF.
- power-up: OFF to GND_TEST, or to LAUNCH or HALT in single-ended mode.
- ground pass: GND_TEST to SUP_TEST.
- rail pass: SUP_TEST to LAUNCH, or to HALT if the reset pin is low.
- go: LAUNCH to RUN.
- reset entry: RUN or TRIP to HALT.
- reset release: HALT to LAUNCH.
- overcurrent: RUN to TRIP.

Top module: `startup_short_seq`

## Requirements
- R1: While `rst_n` is low, and in state OFF (supply not valid), the outputs are `shdn_n_o`=0, `hiz_o`=1, `start_sw_o`=0 and `ready_o`=0, and both status outputs read zero.
- R2: Let S be `settle_i` and C be CLEAN_N. When `supply_ok_i` rises in a bridged mode (`mode_i` not 2'b10) with no shorts present, `start_sw_o` pulses 2S+2C+3 cycles after the edge that first sees the supply valid. Each phase takes S+C+1 cycles, followed by one LAUNCH cycle.
- R3: The ground phase runs before the rail phase. Each phase responds only to its own comparator vector: `gnd_short_i` in GND_TEST and `sup_short_i` in SUP_TEST.
- R4: Within a phase, a sample is taken on every cycle after the first S cycles. A phase passes only after C consecutive samples in which no bit of its comparator vector is set. A short that is seen only during the settle cycles has no effect.
- R5: If a phase has not passed by cycle TMO_CYC-1 after it was entered or last restarted, it restarts its settle and its clean run on the next cycle.
- R6: `shdn_n_o` stays 0 and `hiz_o` stays 1 from supply-valid until the cycle of the start strobe.
- R7: The device reset input `dev_rst_n_i` has no effect during GND_TEST and SUP_TEST.
- R8: The start strobe lasts exactly one cycle, and `ready_o` rises on the cycle after it. If `dev_rst_n_i` is low when the rail phase passes, the block waits in HALT (`shdn_n_o`=1, `hiz_o`=1, `ready_o`=0) and strobes on the cycle after the reset pin goes high.
- R9: In RUN, a low `dev_rst_n_i` drops `ready_o` on the next cycle and enters HALT. Releasing the pin strobes on the next cycle, without a new check.
- R10: In single-ended mode (`mode_i`=2'b10), the test is skipped and the strobe appears on the cycle after the supply-valid edge. Comparator inputs are ignored and no status is recorded.
- R11: `ocp_i` high in RUN drops `ready_o` on the next cycle, with `shdn_n_o`=0 and `hiz_o`=1. This state persists after `ocp_i` falls, until a device reset low and high again produces a new strobe.
- R12: If `supply_ok_i` goes low, the block returns to OFF on the next cycle. The next supply-valid edge runs the full two-phase check again.
- R13: The sticky status is cleared only by `rst_n`. `fail_phase_o[0]` records a ground short seen in a sampling cycle, and `fail_phase_o[1]` records a rail short seen in a sampling cycle. `fail_hb_o` accumulates the OR of the offending comparator bits from such samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset of the logic |
| supply_ok_i | input | 1 | Logic supply valid |
| dev_rst_n_i | input | 1 | Device reset pin, active low |
| mode_i | input | 2 | Output mode: 00 bridged, 01 parallel bridged, 10 single-ended, 11 treated as bridged |
| settle_i | input | CW | Settle cycles before sampling in each phase |
| gnd_short_i | input | NHB | Per-half-bridge output-to-ground comparator |
| sup_short_i | input | NHB | Per-half-bridge output-to-rail comparator |
| ocp_i | input | 1 | Overcurrent event |
| shdn_n_o | output | 1 | Shutdown indication, active low |
| hiz_o | output | 1 | Hold all half-bridges in high impedance |
| start_sw_o | output | 1 | One-cycle start-switching strobe |
| ready_o | output | 1 | Normal operation flag |
| fail_phase_o | output | 2 | Sticky: bit 0 ground short seen, bit 1 rail short seen |
| fail_hb_o | output | NHB | Sticky OR of offending half-bridges |

## Verification
The assertions rely on a few facts about the inputs:
- CLEAN_N and TMO_CYC are at least 1 and 2 respectively.
- `mode_i` is steady while supply is valid.
- An overcurrent is only meaningful while the reset pin and supply are both high.

The stimulus holds the mode constant across each power-up. It changes every input only at the falling clock edge. It keeps the settle count plus the clean run inside one timeout window, except in cases built on purpose to cross the window. It raises overcurrent only in RUN with the reset pin high.

// File: rtl/ssq_pkg.sv
package ssq_pkg;

    typedef enum logic [2:0] {
        SQ_OFF    = 3'd0,
        SQ_GND    = 3'd1,
        SQ_SUP    = 3'd2,
        SQ_LAUNCH = 3'd3,
        SQ_RUN    = 3'd4,
        SQ_HALT   = 3'd5,
        SQ_TRIP   = 3'd6
    } seq_state_e;

    localparam logic [1:0] MODE_SE = 2'b10;
    localparam int         N_PHASE = 2;

endpackage

// File: rtl/ssq_timer.sv
module ssq_timer #(
    parameter int TMO_CYC = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    output logic tmo
);
    localparam int TW = (TMO_CYC > 1) ? $clog2(TMO_CYC) : 1;

    logic [TW-1:0] tcnt_q;

    assign tmo = active && (tcnt_q == TW'(TMO_CYC - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tcnt_q <= '0;
        end else if (!active || tmo) begin
            tcnt_q <= '0;
        end else begin
            tcnt_q <= tcnt_q + 1'b1;
        end
    end

    // R5
    tmo_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tmo |=> !tmo);

endmodule

// File: rtl/ssq_qual.sv
module ssq_qual #(
    parameter int CW      = 8,
    parameter int CLEAN_N = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          active,
    input  logic          restart,
    input  logic [CW-1:0] settle_i,
    input  logic          short_any,
    output logic          sampling,
    output logic          pass
);
    localparam int NW = $clog2(CLEAN_N + 1);

    logic [CW-1:0] scnt_q;
    logic [NW-1:0] ccnt_q;

    assign sampling = active && (scnt_q == settle_i);
    assign pass     = active && (ccnt_q == NW'(CLEAN_N));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scnt_q <= '0;
            ccnt_q <= '0;
        end else if (!active || restart) begin
            scnt_q <= '0;
            ccnt_q <= '0;
        end else if (scnt_q != settle_i) begin
            scnt_q <= scnt_q + 1'b1;
        end else if (short_any) begin
            ccnt_q <= '0;
        end else if (ccnt_q != NW'(CLEAN_N)) begin
            ccnt_q <= ccnt_q + 1'b1;
        end
    end

    // R4
    pass_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pass |-> $past(!short_any));

endmodule

// File: rtl/ssq_status.sv
module ssq_status #(
    parameter int NHB = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           rec_gnd,
    input  logic           rec_sup,
    input  logic [NHB-1:0] gnd_bits,
    input  logic [NHB-1:0] sup_bits,
    output logic [1:0]     fail_phase,
    output logic [NHB-1:0] fail_hb
);
    logic [NHB-1:0] g_hit, s_hit;

    assign g_hit = rec_gnd ? gnd_bits : '0;
    assign s_hit = rec_sup ? sup_bits : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fail_phase <= '0;
            fail_hb    <= '0;
        end else begin
            if (|g_hit) fail_phase[0] <= 1'b1;
            if (|s_hit) fail_phase[1] <= 1'b1;
            fail_hb <= fail_hb | g_hit | s_hit;
        end
    end

    // R13
    sticky_hb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(fail_hb) & ~fail_hb) == '0));

endmodule

// File: rtl/startup_short_seq.sv
module startup_short_seq
    import ssq_pkg::*;
#(
    parameter int NHB     = 4,
    parameter int CW      = 8,
    parameter int CLEAN_N = 4,
    parameter int TMO_CYC = 4096
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           supply_ok_i,
    input  logic           dev_rst_n_i,
    input  logic [1:0]     mode_i,
    input  logic [CW-1:0]  settle_i,
    input  logic [NHB-1:0] gnd_short_i,
    input  logic [NHB-1:0] sup_short_i,
    input  logic           ocp_i,
    output logic           shdn_n_o,
    output logic           hiz_o,
    output logic           start_sw_o,
    output logic           ready_o,
    output logic [1:0]     fail_phase_o,
    output logic [NHB-1:0] fail_hb_o
);
    seq_state_e state_q, state_d;

    logic [N_PHASE-1:0] ph_active, ph_pass, ph_samp, ph_tmo;
    logic [NHB-1:0]     ph_bits [N_PHASE];

    assign ph_bits[0]   = gnd_short_i;
    assign ph_bits[1]   = sup_short_i;
    assign ph_active[0] = (state_q == SQ_GND);
    assign ph_active[1] = (state_q == SQ_SUP);

    for (genvar g = 0; g < N_PHASE; g++) begin : g_phase
        ssq_timer #(.TMO_CYC(TMO_CYC)) u_tmr (
            .clk    (clk),
            .rst_n  (rst_n),
            .active (ph_active[g]),
            .tmo    (ph_tmo[g])
        );
        ssq_qual #(.CW(CW), .CLEAN_N(CLEAN_N)) u_qual (
            .clk       (clk),
            .rst_n     (rst_n),
            .active    (ph_active[g]),
            .restart   (ph_tmo[g]),
            .settle_i  (settle_i),
            .short_any (|ph_bits[g]),
            .sampling  (ph_samp[g]),
            .pass      (ph_pass[g])
        );
    end

    ssq_status #(.NHB(NHB)) u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .rec_gnd    (ph_samp[0]),
        .rec_sup    (ph_samp[1]),
        .gnd_bits   (gnd_short_i),
        .sup_bits   (sup_short_i),
        .fail_phase (fail_phase_o),
        .fail_hb    (fail_hb_o)
    );

    // next state
    always_comb begin
        state_d = state_q;
        if (!supply_ok_i) begin
            state_d = SQ_OFF;
        end else begin
            unique case (state_q)
                SQ_OFF: begin
                    if (mode_i == MODE_SE) state_d = dev_rst_n_i ? SQ_LAUNCH : SQ_HALT;
                    else                   state_d = SQ_GND;
                end
                SQ_GND:    if (ph_pass[0]) state_d = SQ_SUP;
                SQ_SUP:    if (ph_pass[1]) state_d = dev_rst_n_i ? SQ_LAUNCH : SQ_HALT;
                SQ_LAUNCH: state_d = SQ_RUN;
                SQ_RUN: begin
                    if (!dev_rst_n_i) state_d = SQ_HALT;
                    else if (ocp_i)   state_d = SQ_TRIP;
                end
                SQ_HALT:   if (dev_rst_n_i) state_d = SQ_LAUNCH;
                SQ_TRIP:   if (!dev_rst_n_i) state_d = SQ_HALT;
                default:   state_d = SQ_OFF;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SQ_OFF;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        shdn_n_o   = 1'b0;
        hiz_o      = 1'b1;
        start_sw_o = 1'b0;
        ready_o    = 1'b0;
        unique case (state_q)
            SQ_OFF, SQ_GND, SQ_SUP, SQ_TRIP: begin
                shdn_n_o = 1'b0;
                hiz_o    = 1'b1;
            end
            SQ_LAUNCH: begin
                shdn_n_o   = 1'b1;
                hiz_o      = 1'b0;
                start_sw_o = 1'b1;
            end
            SQ_RUN: begin
                shdn_n_o = 1'b1;
                hiz_o    = 1'b0;
                ready_o  = 1'b1;
            end
            SQ_HALT: begin
                shdn_n_o = 1'b1;
                hiz_o    = 1'b1;
            end
            default: begin
                shdn_n_o = 1'b0;
                hiz_o    = 1'b1;
            end
        endcase
    end

    // R8
    strobe_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_sw_o |=> !start_sw_o);

    // R8
    ready_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready_o) |-> $past(start_sw_o));

    // R11
    ocp_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_o && ocp_i && dev_rst_n_i && supply_ok_i) |=> !ready_o);

    // R10
    se_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SQ_OFF && supply_ok_i && dev_rst_n_i && mode_i == MODE_SE) |=> start_sw_o);

    // R6
    test_shdn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SQ_SUP && !ph_pass[1] && supply_ok_i) |=> (!shdn_n_o && hiz_o));

endmodule

// File: tb/tb_startup_short_seq.sv
module tb_startup_short_seq;
    localparam int NHB = 4;
    localparam int CW  = 4;
    localparam int CN  = 3;
    localparam int TMO = 40;

    logic clk = 1'b0;
    logic rst_n, supply_ok, dev_rst_n, ocp;
    logic [1:0] mode;
    logic [CW-1:0] settle;
    logic [NHB-1:0] gsh, ssh;
    logic shdn_n, hiz, start_sw, ready;
    logic [1:0] fph;
    logic [NHB-1:0] fhb;

    int n_chk = 0;
    int n_err = 0;

    always #10 clk = ~clk;

    startup_short_seq #(.NHB(NHB), .CW(CW), .CLEAN_N(CN), .TMO_CYC(TMO)) dut (
        .clk(clk), .rst_n(rst_n), .supply_ok_i(supply_ok), .dev_rst_n_i(dev_rst_n),
        .mode_i(mode), .settle_i(settle), .gnd_short_i(gsh), .sup_short_i(ssh),
        .ocp_i(ocp), .shdn_n_o(shdn_n), .hiz_o(hiz), .start_sw_o(start_sw),
        .ready_o(ready), .fail_phase_o(fph), .fail_hb_o(fhb)
    );

    task automatic chk_eq(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // absolute cycle of pass for a phase entered at n0, comparator clean from clr on
    function automatic int calc_pass(input int n0, input int s, input int clr);
        int base = n0;
        int p;
        for (int i = 0; i < 20; i++) begin
            p = max2(base + s, clr) + CN;
            if (p - base <= TMO - 1) return p;
            base += TMO;
        end
        return -1;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; supply_ok = 1'b0; dev_rst_n = 1'b1; ocp = 1'b0;
        mode = 2'b00; gsh = '0; ssh = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // supply up, wait for strobe; returns cycles to strobe
    task automatic power_up(output int nl);
        int n = 0;
        nl = -1;
        supply_ok = 1'b1;
        while (n < 400 && nl < 0) begin
            @(negedge clk);
            n++;
            if (start_sw) nl = n;
        end
        @(negedge clk);
    endtask

    task automatic run_case(input int s, input int gl, input int smode, input int rt,
                            input logic [NHB-1:0] gm, input logic [NHB-1:0] sm);
        int pg, ps, sl, n, nl, hold_ok;
        logic [1:0] eph;
        logic [NHB-1:0] ehb;
        do_reset();
        settle = CW'(s);
        pg = calc_pass(1, s, gl + 1);
        sl = smode ? pg + s + 3 : 0;
        ps = calc_pass(pg + 1, s, sl + 1);
        supply_ok = 1'b1;
        n = 0; nl = -1; hold_ok = 1;
        while (n < 400 && nl < 0) begin
            @(negedge clk);
            n++;
            if (start_sw) nl = n;
            else if (shdn_n || !hiz || ready) hold_ok = 0;
            gsh = (n <= gl) ? gm : '0;
            ssh = (n <= sl) ? sm : '0;
            dev_rst_n = (rt != 0 && n >= 2 && n <= 5) ? 1'b0 : 1'b1;
        end
        chk_eq($sformatf("R2 R3 R4 R5 R7 strobe cycle s=%0d gl=%0d sl=%0d", s, gl, sl), nl, ps + 1);
        chk_eq("R6 shutdown and hiz held during check", hold_ok, 1);
        @(negedge clk);
        chk_eq("R8 ready after strobe", int'(ready), 1);
        chk_eq("R8 strobe single cycle", int'(start_sw), 0);
        eph = {sl >= pg + 1 + s, gl >= 1 + s};
        ehb = (eph[0] ? gm : '0) | (eph[1] ? sm : '0);
        chk_eq("R13 sticky phase", int'(fph), int'(eph));
        chk_eq("R13 sticky half-bridge", int'(fhb), int'(ehb));
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin : main
        int nl, gls[6];
        rst_n = 1'b0; supply_ok = 1'b0; dev_rst_n = 1'b1; ocp = 1'b0;
        mode = 2'b00; settle = '0; gsh = '0; ssh = '0;
        gls = '{0, 2, 4, 6, 41, 85};

        // R1 reset and OFF state
        @(negedge clk);
        chk_eq("R1 shdn in reset", int'(shdn_n), 0);
        chk_eq("R1 hiz in reset", int'(hiz), 1);
        chk_eq("R1 ready in reset", int'(ready), 0);
        do_reset();
        chk_eq("R1 OFF strobe", int'(start_sw), 0);
        chk_eq("R1 OFF status", int'({fph, fhb}), 0);

        // sweep
        for (int s = 0; s < 5; s++)
            for (int gi = 0; gi < 6; gi++)
                for (int sm = 0; sm < 2; sm++)
                    for (int rt = 0; rt < 2; rt++)
                        run_case(s, gls[gi], sm, rt,
                                 NHB'(1 << (gi % NHB)), NHB'(1 << ((s + 1) % NHB)));

        // R8 pass with device reset held low
        do_reset();
        settle = 4'd1; dev_rst_n = 1'b0; supply_ok = 1'b1;
        begin
            int n = 0;
            while (n < 100 && !shdn_n) begin @(negedge clk); n++; end
            chk_eq("R8 halt entry cycle", n, 2 * (1 + CN + 1) + 1);
        end
        chk_eq("R8 halt hiz", int'(hiz), 1);
        chk_eq("R8 halt ready", int'(ready), 0);
        repeat (5) @(negedge clk);
        chk_eq("R8 halt no strobe", int'(start_sw), 0);
        dev_rst_n = 1'b1;
        @(negedge clk);
        chk_eq("R8 strobe after release", int'(start_sw), 1);
        @(negedge clk);
        chk_eq("R8 ready after release", int'(ready), 1);

        // R9 later device reset, no new check
        dev_rst_n = 1'b0;
        @(negedge clk);
        chk_eq("R9 ready drops", int'(ready), 0);
        chk_eq("R9 shdn high in reset", int'(shdn_n), 1);
        chk_eq("R9 hiz in reset", int'(hiz), 1);
        gsh = '1; ssh = '1;
        repeat (8) @(negedge clk);
        dev_rst_n = 1'b1;
        @(negedge clk);
        chk_eq("R9 immediate strobe", int'(start_sw), 1);
        @(negedge clk);
        chk_eq("R9 ready again", int'(ready), 1);
        gsh = '0; ssh = '0;

        // R11 overcurrent
        ocp = 1'b1;
        @(negedge clk);
        ocp = 1'b0;
        chk_eq("R11 ready drops", int'(ready), 0);
        chk_eq("R11 shdn low", int'(shdn_n), 0);
        chk_eq("R11 hiz", int'(hiz), 1);
        repeat (6) @(negedge clk);
        chk_eq("R11 latched", int'(ready | start_sw), 0);
        dev_rst_n = 1'b0;
        @(negedge clk);
        chk_eq("R11 reset releases shdn", int'(shdn_n), 1);
        dev_rst_n = 1'b1;
        @(negedge clk);
        chk_eq("R11 strobe after reset", int'(start_sw), 1);
        @(negedge clk);
        chk_eq("R11 ready after reset", int'(ready), 1);

        // R12 supply loss and re-check
        supply_ok = 1'b0;
        @(negedge clk);
        chk_eq("R12 off ready", int'(ready), 0);
        chk_eq("R12 off shdn", int'(shdn_n), 0);
        chk_eq("R12 off hiz", int'(hiz), 1);
        settle = 4'd2;
        power_up(nl);
        chk_eq("R12 full check again", nl, 2 * 2 + 2 * CN + 3);

        // R10 single-ended skip
        do_reset();
        mode = 2'b10; settle = 4'd3; gsh = '1; ssh = '1;
        power_up(nl);
        chk_eq("R10 strobe next cycle", nl, 1);
        chk_eq("R10 ready", int'(ready), 1);
        chk_eq("R10 no status", int'({fph, fhb}), 0);

        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule